// File: doc/BRIEF.md
# Control-Bit Serial Stream Generator

This block produces the per-slot control output of a time-division switch that has 8 serial streams of 32 channels each. Every stream/channel slot owns one control bit, kept in an external table of 256 single-bit entries. The block reads that table in a fixed interleaved order and shifts one bit onto `csOut` in each bit period. It stays in step with the TDM frame through a frame pulse and the bit clock. The output runs at the 2.048 Mb/s stream rate, so a frame holds exactly 256 control bits.

Each bit goes out one channel period ahead of the data channel it describes, which gives external circuitry time to react. Within a channel, the eight bit periods carry the eight streams, most significant bit position first. Output position (channel k, bit b) therefore carries the bit of stream 7-b, channel (k+1) mod 32. The table is read through a synchronous port with one clock of latency. The block issues each address one bit period before the bit is needed, so `csOut` can follow the returned data directly.

Top module: `csg_top`

## Requirements
- R1: While `rstN` is low, `csOut` is 0.
- R2: After reset is released, `csOut` stays 0 until the first clock edge at which `frameSync` is sampled high.
- R3: A clock edge with `frameSync` high makes the following bit period channel 0, bit 7 (bit periods are sent MSB first, bit 7 down to bit 0). Each later clock advances by one bit period. After channel 31, bit 0 the count wraps to channel 0, bit 7 without any pulse.
- R4: During channel k, bit b, `csOut` equals the table entry at index s*32 + c, where s = 7-b and c = (k+1) mod 32. A stored 1 is sent high and a stored 0 is sent low.
- R5: Entry 0 (stream 0, channel 0) is sent in channel 31, bit 7. Entry 32 (stream 1, channel 0) is sent in channel 31, bit 6.
- R6: `memRdAddr` carries the index of the bit for the next bit period. The table returns `memRdData` one clock later, and whenever `csOut` is driven high, `memRdData` is high.
- R7: A frame pulse that arrives when the count is not at channel 31, bit 0 realigns the count. `csOut` is then held at 0 for the single bit period that follows the pulse. A pulse that arrives at channel 31, bit 0 causes no such gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one rising edge per bit period |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Active-high frame pulse, sampled in the last bit period of a frame |
| memRdAddr | output | 8 | Table index of the bit to be sent in the next bit period (stream*32 + channel) |
| memRdData | input | 1 | Table entry for the address presented in the previous bit period |
| csOut | output | 1 | Serial control bit stream |

## Verification
The bench builds the block with its default 8 streams and 32 channels. At that size the whole 256-entry table fits in a handful of frames. Every bit period of every frame is compared against an index computed arithmetically from the channel and bit number, across uniform, stream-striped, channel-striped, random and single-set-entry tables. Each run also covers a misaligned first pulse, an aligned pulse and a frame that wraps without a pulse.

// File: rtl/csg_pkg.sv
package csg_pkg;

  // Strobes passed from the sequencing control to the datapath.
  typedef struct packed {
    logic drive;      // output may follow the table data this period
    logic endOfChan;  // current bit period is the last one of its channel
  } ctlStrobe_t;

endpackage

// File: rtl/csg_ctrl.sv
module csg_ctrl
  import csg_pkg::*;
#(
  parameter int STREAMS  = 8,
  parameter int CHANNELS = 32,
  localparam int BIT_W   = $clog2(STREAMS),
  localparam int CH_W    = $clog2(CHANNELS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameSync,
  output logic [BIT_W-1:0] bitIdx,
  output logic [CH_W-1:0]  chanIdx,
  output ctlStrobe_t       strobe
);

  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(STREAMS - 1);
  localparam logic [CH_W-1:0]  LAST_CHAN = CH_W'(CHANNELS - 1);

  logic started;
  logic stale;
  logic bitWrap;
  logic atFrameEnd;

  assign bitWrap    = (bitIdx == LAST_BIT);
  assign atFrameEnd = bitWrap && (chanIdx == LAST_CHAN);

  // Position counter: bitIdx 0 is the MSB period of a channel.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx  <= LAST_BIT;
      chanIdx <= LAST_CHAN;
    end else if (frameSync) begin
      bitIdx  <= '0;
      chanIdx <= '0;
    end else if (bitWrap) begin
      bitIdx  <= '0;
      chanIdx <= (chanIdx == LAST_CHAN) ? '0 : chanIdx + 1'b1;
    end else begin
      bitIdx  <= bitIdx + 1'b1;
    end
  end

  // Output qualification: off until the first pulse, and off for one
  // period after a pulse that broke the running count.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started <= 1'b0;
      stale   <= 1'b0;
    end else if (frameSync) begin
      started <= 1'b1;
      stale   <= !atFrameEnd;
    end else begin
      stale   <= 1'b0;
    end
  end

  always_comb begin
    strobe.drive     = started && !stale;
    strobe.endOfChan = bitWrap;
  end

endmodule

// File: rtl/csg_datapath.sv
module csg_datapath
  import csg_pkg::*;
#(
  parameter int STREAMS  = 8,
  parameter int CHANNELS = 32,
  localparam int BIT_W   = $clog2(STREAMS),
  localparam int CH_W    = $clog2(CHANNELS),
  localparam int ADDR_W  = $clog2(STREAMS * CHANNELS)
) (
  input  logic [BIT_W-1:0]  bitIdx,
  input  logic [CH_W-1:0]   chanIdx,
  input  ctlStrobe_t        strobe,
  input  logic              memRdData,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              csOut
);

  localparam logic [CH_W-1:0] LAST_CHAN = CH_W'(CHANNELS - 1);

  logic [BIT_W-1:0] nextBit;
  logic [CH_W-1:0]  nextChan;
  logic [CH_W-1:0]  leadChan;

  // Position of the coming bit period.
  always_comb begin
    nextBit  = strobe.endOfChan ? '0 : bitIdx + 1'b1;
    if (!strobe.endOfChan)          nextChan = chanIdx;
    else if (chanIdx == LAST_CHAN)  nextChan = '0;
    else                            nextChan = chanIdx + 1'b1;
  end

  // Bits lead their data channel by one channel period.
  assign leadChan = (nextChan == LAST_CHAN) ? '0 : nextChan + 1'b1;

  // Stream carried in a bit period equals its bit index (MSB = stream 0).
  assign memRdAddr = ADDR_W'(int'(nextBit) * CHANNELS + int'(leadChan));

  assign csOut = strobe.drive && memRdData;

endmodule

// File: rtl/csg_top.sv
module csg_top
  import csg_pkg::*;
#(
  parameter int STREAMS  = 8,
  parameter int CHANNELS = 32,
  localparam int BIT_W   = $clog2(STREAMS),
  localparam int CH_W    = $clog2(CHANNELS),
  localparam int ADDR_W  = $clog2(STREAMS * CHANNELS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdData,
  output logic              csOut
);

  logic [BIT_W-1:0] bitIdx;
  logic [CH_W-1:0]  chanIdx;
  ctlStrobe_t       strobe;

  csg_ctrl #(.STREAMS(STREAMS), .CHANNELS(CHANNELS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameSync (frameSync),
    .bitIdx    (bitIdx),
    .chanIdx   (chanIdx),
    .strobe    (strobe)
  );

  csg_datapath #(.STREAMS(STREAMS), .CHANNELS(CHANNELS)) u_dp (
    .bitIdx    (bitIdx),
    .chanIdx   (chanIdx),
    .strobe    (strobe),
    .memRdData (memRdData),
    .memRdAddr (memRdAddr),
    .csOut     (csOut)
  );

endmodule

// File: rtl/csg_checker.sv
module csg_checker #(
  parameter int STREAMS  = 8,
  parameter int CHANNELS = 32,
  localparam int BIT_W   = $clog2(STREAMS),
  localparam int CH_W    = $clog2(CHANNELS),
  localparam int ADDR_W  = $clog2(STREAMS * CHANNELS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameSync,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              memRdData,
  input logic              csOut
);

  logic [BIT_W-1:0] addrStream;
  logic [CH_W-1:0]  addrChan;
  assign addrStream = memRdAddr[ADDR_W-1:CH_W];
  assign addrChan   = memRdAddr[CH_W-1:0];

  a_r1_low_in_reset: assert property (@(posedge clk) !rstN |-> !csOut);

  a_r4_stream_step: assert property (@(posedge clk) disable iff (!rstN)
    !frameSync |=> addrStream == BIT_W'($past(addrStream) + 1'b1));

  a_r4_chan_step: assert property (@(posedge clk) disable iff (!rstN)
    (!frameSync && addrStream == BIT_W'(STREAMS - 1))
      |=> addrChan == CH_W'(($past(addrChan) == CH_W'(CHANNELS - 1)) ? 0 : $past(addrChan) + 1'b1));

  a_r4_chan_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!frameSync && addrStream != BIT_W'(STREAMS - 1)) |=> $stable(addrChan));

  a_r3_sync_addr: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> memRdAddr == ADDR_W'(CHANNELS + 1));

  a_r7_stale_low: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && memRdAddr != ADDR_W'(1)) |=> !csOut);

  a_r6_follow: assert property (@(posedge clk) disable iff (!rstN)
    csOut |-> memRdData);

endmodule

bind csg_top csg_checker #(.STREAMS(STREAMS), .CHANNELS(CHANNELS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .frameSync (frameSync),
  .memRdAddr (memRdAddr),
  .memRdData (memRdData),
  .csOut     (csOut)
);

// File: tb/tb_csg_top.sv
module tb_csg_top;

  localparam int S = 8;
  localparam int C = 32;
  localparam int N = S * C;

  logic       clk = 1'b0;
  logic       rstN;
  logic       frameSync;
  logic [7:0] memRdAddr;
  logic       memRdData;
  logic       csOut;
  logic       ctlMem [N];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  // Synchronous single-bit table, one clock of read latency.
  always @(posedge clk) memRdData <= ctlMem[memRdAddr];

  csg_top dut (
    .clk       (clk),
    .rstN      (rstN),
    .frameSync (frameSync),
    .memRdAddr (memRdAddr),
    .memRdData (memRdData),
    .csOut     (csOut)
  );

  function automatic int slotOf(int p);
    int k = (p / S) % C;
    int b = (S - 1) - (p % S);
    return (S - 1 - b) * C + ((k + 1) % C);
  endfunction

  task automatic check(string req, int act, int exp, int p);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at position %0d: actual %0d expected %0d", req, p, act, exp);
    end
  endtask

  task automatic fillTable(int kind, int arg);
    for (int i = 0; i < N; i++) begin
      case (kind)
        0: ctlMem[i] = 1'b1;
        1: ctlMem[i] = 1'b0;
        2: ctlMem[i] = 1'((i / C) % 2);
        3: ctlMem[i] = 1'((i % C) % 2);
        4: ctlMem[i] = 1'($urandom);
        default: ctlMem[i] = (i == arg);
      endcase
    end
  endtask

  task automatic runFrame(bit pulse, bit mis);
    frameSync = pulse;
    @(negedge clk);
    frameSync = 1'b0;
    for (int p = 0; p < N; p++) begin
      string req;
      int exp;
      if (p > 0) @(negedge clk);
      exp = (mis && p == 0) ? 0 : int'(ctlMem[slotOf(p)]);
      if (mis && p == 0)       req = "R7";
      else if (p == N - S)     req = "R5 slot0";
      else if (p == N - S + 1) req = "R5 slot32";
      else if (!pulse)         req = "R3 wrap";
      else                     req = "R4";
      check(req, int'(csOut), exp, p);
      check("R6 addr", int'(memRdAddr), slotOf((p + 1) % N), p);
    end
  endtask

  task automatic runPattern(int kind, int arg);
    @(negedge clk);
    rstN = 1'b0;
    frameSync = 1'b0;
    fillTable(kind, arg);
    repeat (3) begin
      @(negedge clk);
      check("R1", int'(csOut), 0, -1);
    end
    rstN = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check("R2", int'(csOut), 0, -1);
    end
    runFrame(1'b1, 1'b1);   // misaligned first pulse
    runFrame(1'b1, 1'b0);   // aligned pulse
    runFrame(1'b0, 1'b0);   // free wrap
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: run hung after %0d cycles, expected under %0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rstN = 1'b0;
    frameSync = 1'b0;
    fillTable(0, 0);
    runPattern(0, 0);
    runPattern(1, 0);
    runPattern(2, 0);
    runPattern(3, 0);
    runPattern(4, 0);
    runPattern(4, 0);
    runPattern(5, 0);
    runPattern(5, 32);
    runPattern(5, N - 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule